// File: doc/BRIEF.md
# Trap Entry Sequencer with Register Window Rotation

This block carries out the state changes a processor makes when it takes a trap. A one-cycle trap request arrives with an 8-bit trap type. The block then captures the current processor state from its inputs: the window pointer, the trap-enable, supervisor and trap-base values, and the two program counters. It runs a fixed two-cycle sequence. In the first cycle it writes the old program counter into a local register of the new window, through a register file write port. In the second cycle it writes the old next program counter the same way. On that second cycle it also presents the new processor state on its outputs, qualified by a one-cycle done pulse. The processor loads the new state on that pulse.

The new window is one below the current one and wraps modulo the window count. The new program counter is the trap vector: the kept upper bits of the trap base, with the trap type placed in bits [11:4]. If a trap is requested while traps are disabled, the block writes nothing and signals nothing as complete. It moves to an error state that only a reset clears.

Top module: `trap_entry_seq`

## Requirements
- R1: A request taken while `cur_et` is 0 raises `err_state` from the next cycle. `err_state` stays high until reset. In that state no register file write and no `done` ever occur, and later requests are ignored.
- R2: A request accepted at clock edge k makes `busy` high for the two cycles after k. `done` is high only in the second of them. `busy` is low again after edge k+2. Requests seen while `busy` is high are ignored.
- R3: On `done`, `nxt_cwp` equals (captured `cur_cwp` − 1) mod NWIN. A window pointer of 0 becomes NWIN−1.
- R4: On `done`, `nxt_et` is 0, `nxt_s` is 1, and `nxt_ps` equals the captured `cur_s`.
- R5: On `done`, `nxt_tbr` has bits [31:12] from the captured `cur_tbr`, bits [11:4] equal to the trap type, and bits [3:0] at 0.
- R6: On `done`, `nxt_pc` equals `nxt_tbr` and `nxt_npc` equals `nxt_tbr` + 4.
- R7: The first busy cycle writes the captured `cur_pc` to register 17 (local 1) of window `nxt_cwp`. The second busy cycle writes the captured `cur_npc` to register 18 (local 2) of the same window.
- R8: All inputs are captured at the accepting edge. Changes to them while `busy` is high have no effect on the results.
- R9: After reset, `busy`, `done`, `err_state` and `rf_we` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trap_req | input | 1 | Trap request, sampled while idle |
| trap_type | input | 8 | Trap type code |
| cur_cwp | input | 3 | Current window pointer |
| cur_et | input | 1 | Current trap-enable bit |
| cur_s | input | 1 | Current supervisor bit |
| cur_tbr | input | 32 | Current trap base register |
| cur_pc | input | 32 | Current program counter |
| cur_npc | input | 32 | Current next program counter |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Last cycle of the sequence; nxt_* valid |
| err_state | output | 1 | Sticky error: trap taken with traps disabled |
| rf_we | output | 1 | Register file write enable |
| rf_win | output | 3 | Window of the register file write |
| rf_reg | output | 5 | Register index within the window |
| rf_wdata | output | 32 | Register file write data |
| nxt_cwp | output | 3 | New window pointer |
| nxt_et | output | 1 | New trap-enable bit |
| nxt_s | output | 1 | New supervisor bit |
| nxt_ps | output | 1 | New previous-supervisor bit |
| nxt_tbr | output | 32 | New trap base register |
| nxt_pc | output | 32 | New program counter |
| nxt_npc | output | 32 | New next program counter |

## Verification
Traps are issued with window pointers in the middle of the range, at 0 (which shows whether the decrement wraps) and at NWIN−1. Each is tried with both supervisor values, so a swapped or forgotten previous-supervisor copy becomes visible. Trap bases with all-ones low bits and varied trap types show whether the low base bits are kept or the type lands in the wrong field. Changed inputs and a second request during a running sequence show whether the inputs are captured once. A final request with traps disabled shows the error state, its stickiness and its silence on the write port.

// File: rtl/trap_seq_pkg.sv
// Shared types for the trap entry sequencer.
// Assumes: register indices follow the window layout where locals start at 16.
package trap_seq_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_LOC1 = 2'd1,
        SEQ_LOC2 = 2'd2,
        SEQ_HALT = 2'd3
    } seq_state_t;

    localparam logic [4:0] LOC1_IDX = 5'd17;
    localparam logic [4:0] LOC2_IDX = 5'd18;
endpackage

// File: rtl/trap_wnd_dec.sv
// Computes the window below the given one, modulo NWIN.
// Assumes: NWIN is a power of two and at least 2.
module trap_wnd_dec #(
    parameter int NWIN  = 8,
    localparam int CW_W = $clog2(NWIN)
) (
    input  logic [CW_W-1:0] cwp_i,
    output logic [CW_W-1:0] cwp_o
);
    generate
        if (CW_W == 1) begin : g_pair
            // two windows: decrement is inversion
            assign cwp_o = ~cwp_i;
        end else begin : g_wide
            // power-of-two count: truncation gives the modulo
            assign cwp_o = cwp_i - {{(CW_W-1){1'b0}}, 1'b1};
        end
    endgenerate
endmodule

// File: rtl/trap_vec_gen.sv
// Builds the trap base, new PC and new next-PC from the kept base bits and trap type.
// Assumes: the trap type sits just above a 4-bit zero field.
module trap_vec_gen #(
    parameter int XLEN = 32,
    parameter int TT_W = 8,
    localparam int LO  = TT_W + 4
) (
    input  logic [XLEN-LO-1:0] base_i,
    input  logic [TT_W-1:0]    tt_i,
    output logic [XLEN-1:0]    tbr_o,
    output logic [XLEN-1:0]    pc_o,
    output logic [XLEN-1:0]    npc_o
);
    // vector assembly and next-PC increment
    always_comb begin
        tbr_o = {base_i, tt_i, 4'b0000};
        pc_o  = tbr_o;
        npc_o = tbr_o + XLEN'(4);
    end
endmodule

// File: rtl/trap_seq_fsm.sv
// Sequences trap entry: idle, two write cycles, or sticky error.
// Assumes: req_i is looked at only while idle.
module trap_seq_fsm
    import trap_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_i,
    input  logic       et_i,
    output seq_state_t state_o,
    output logic       accept_o
);
    seq_state_t state_q;

    assign accept_o = (state_q == SEQ_IDLE) && req_i && et_i;
    assign state_o  = state_q;

    // state register with next-state choice
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
        end else begin
            unique case (state_q)
                SEQ_IDLE: if (req_i) state_q <= et_i ? SEQ_LOC1 : SEQ_HALT;
                SEQ_LOC1: state_q <= SEQ_LOC2;
                SEQ_LOC2: state_q <= SEQ_IDLE;
                SEQ_HALT: state_q <= SEQ_HALT;
                default:  state_q <= SEQ_HALT;
            endcase
        end
    end

    // R1
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_HALT) |=> (state_q == SEQ_HALT));

    // R2
    seq_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_LOC1) |=> (state_q == SEQ_LOC2));
endmodule

// File: rtl/trap_entry_seq.sv
// Trap entry control: captures processor state on a request, writes the old
// PCs into locals 1 and 2 of the new window, and presents the new state with done.
// Assumes: the processor loads nxt_* on done and holds cur_* meaningful at request.
module trap_entry_seq
    import trap_seq_pkg::*;
#(
    parameter int NWIN  = 8,
    parameter int XLEN  = 32,
    parameter int TT_W  = 8,
    localparam int CW_W = $clog2(NWIN),
    localparam int LO   = TT_W + 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            trap_req,
    input  logic [TT_W-1:0] trap_type,
    input  logic [CW_W-1:0] cur_cwp,
    input  logic            cur_et,
    input  logic            cur_s,
    input  logic [XLEN-1:0] cur_tbr,
    input  logic [XLEN-1:0] cur_pc,
    input  logic [XLEN-1:0] cur_npc,
    output logic            busy,
    output logic            done,
    output logic            err_state,
    output logic            rf_we,
    output logic [CW_W-1:0] rf_win,
    output logic [4:0]      rf_reg,
    output logic [XLEN-1:0] rf_wdata,
    output logic [CW_W-1:0] nxt_cwp,
    output logic            nxt_et,
    output logic            nxt_s,
    output logic            nxt_ps,
    output logic [XLEN-1:0] nxt_tbr,
    output logic [XLEN-1:0] nxt_pc,
    output logic [XLEN-1:0] nxt_npc
);
    seq_state_t         state;
    logic               accept;
    logic [CW_W-1:0]    cwp_q;
    logic               s_q;
    logic [XLEN-LO-1:0] base_q;
    logic [TT_W-1:0]    tt_q;
    logic [XLEN-1:0]    pc_q;
    logic [XLEN-1:0]    npc_q;

    trap_seq_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (trap_req),
        .et_i     (cur_et),
        .state_o  (state),
        .accept_o (accept)
    );

    // capture processor state at the accepting edge only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cwp_q  <= '0;
            s_q    <= 1'b0;
            base_q <= '0;
            tt_q   <= '0;
            pc_q   <= '0;
            npc_q  <= '0;
        end else if (accept) begin
            cwp_q  <= cur_cwp;
            s_q    <= cur_s;
            base_q <= cur_tbr[XLEN-1:LO];
            tt_q   <= trap_type;
            pc_q   <= cur_pc;
            npc_q  <= cur_npc;
        end
    end

    trap_wnd_dec #(.NWIN(NWIN)) u_wnd (
        .cwp_i (cwp_q),
        .cwp_o (nxt_cwp)
    );

    trap_vec_gen #(.XLEN(XLEN), .TT_W(TT_W)) u_vec (
        .base_i (base_q),
        .tt_i   (tt_q),
        .tbr_o  (nxt_tbr),
        .pc_o   (nxt_pc),
        .npc_o  (nxt_npc)
    );

    // status and mode-bit outputs
    always_comb begin
        busy      = (state == SEQ_LOC1) || (state == SEQ_LOC2);
        done      = (state == SEQ_LOC2);
        err_state = (state == SEQ_HALT);
        nxt_et    = 1'b0;
        nxt_s     = 1'b1;
        nxt_ps    = s_q;
    end

    // register file write port: local 1 then local 2 of the new window
    always_comb begin
        rf_we    = busy;
        rf_win   = nxt_cwp;
        rf_reg   = (state == SEQ_LOC1) ? LOC1_IDX : LOC2_IDX;
        rf_wdata = (state == SEQ_LOC1) ? pc_q : npc_q;
    end

    // R1
    err_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_state |-> (!rf_we && !done));

    // R3
    wnd_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (nxt_cwp != cwp_q));

    // R6
    npc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (nxt_npc == nxt_pc + XLEN'(4)));

    // R2
    done_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    hold_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(pc_q) && $stable(tt_q));
endmodule

// File: tb/trap_entry_seq_test.sv
module trap_entry_seq_test;
    localparam int CLK_P = 10;
    localparam int NWIN  = 8;
    localparam int CW_W  = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trap_req = 1'b0;
    logic [7:0]  trap_type = '0;
    logic [2:0]  cur_cwp = '0;
    logic        cur_et = 1'b1;
    logic        cur_s = 1'b0;
    logic [31:0] cur_tbr = '0, cur_pc = '0, cur_npc = '0;
    logic        busy, done, err_state, rf_we, nxt_et, nxt_s, nxt_ps;
    logic [2:0]  rf_win, nxt_cwp;
    logic [4:0]  rf_reg;
    logic [31:0] rf_wdata, nxt_tbr, nxt_pc, nxt_npc;

    int checks = 0;
    int fails  = 0;

    logic [39:0]  rf_q[$];   // {win, reg, data}
    logic [101:0] cm_q[$];   // {cwp, ps, tbr, pc, npc}

    always #(CLK_P/2) clk = ~clk;

    trap_entry_seq uut (
        .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .trap_type(trap_type),
        .cur_cwp(cur_cwp), .cur_et(cur_et), .cur_s(cur_s), .cur_tbr(cur_tbr),
        .cur_pc(cur_pc), .cur_npc(cur_npc), .busy(busy), .done(done),
        .err_state(err_state), .rf_we(rf_we), .rf_win(rf_win), .rf_reg(rf_reg),
        .rf_wdata(rf_wdata), .nxt_cwp(nxt_cwp), .nxt_et(nxt_et), .nxt_s(nxt_s),
        .nxt_ps(nxt_ps), .nxt_tbr(nxt_tbr), .nxt_pc(nxt_pc), .nxt_npc(nxt_npc)
    );

    task automatic check(input bit ok, input string req, input logic [127:0] act,
                         input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: pops expected write and commit items as the design produces them
    always @(negedge clk) begin
        if (rst_n && rf_we) begin
            if (rf_q.size() == 0) check(1'b0, "R7 unexpected write", {rf_win, rf_reg, rf_wdata}, 0);
            else begin
                logic [39:0] e;
                e = rf_q.pop_front();
                check({rf_win, rf_reg, rf_wdata} == e, "R7 write", {rf_win, rf_reg, rf_wdata}, e);
            end
        end
        if (rst_n && done) begin
            if (cm_q.size() == 0) check(1'b0, "R2 unexpected done", 0, 0);
            else begin
                logic [101:0] e;
                e = cm_q.pop_front();
                check({nxt_cwp, nxt_ps, nxt_tbr, nxt_pc, nxt_npc} == e,
                      "R3 R5 R6 R4 commit", {nxt_cwp, nxt_ps, nxt_tbr, nxt_pc, nxt_npc}, e);
                check(nxt_et == 1'b0 && nxt_s == 1'b1, "R4 mode bits", {nxt_et, nxt_s}, 2'b01);
            end
        end
    end

    // driver: issues one trap, pushes expected items, checks timing at the ports
    task automatic do_trap(input logic [2:0] cwp, input logic s, input logic [31:0] tbr,
                           input logic [7:0] tt, input logic [31:0] pc, input logic [31:0] npc,
                           input bit disturb);
        logic [2:0]  ecwp;
        logic [31:0] etbr;
        ecwp = 3'((int'(cwp) + NWIN - 1) % NWIN);
        etbr = (tbr & 32'hFFFF_F000) | (32'(tt) << 4);
        rf_q.push_back({ecwp, 5'd17, pc});
        rf_q.push_back({ecwp, 5'd18, npc});
        cm_q.push_back({ecwp, s, etbr, etbr, etbr + 32'd4});
        @(posedge clk); #1;
        cur_cwp = cwp; cur_s = s; cur_tbr = tbr; trap_type = tt;
        cur_pc = pc; cur_npc = npc; cur_et = 1'b1; trap_req = 1'b1;
        @(posedge clk); #1;
        trap_req = disturb;
        if (disturb) begin
            // R8: new values while busy must not alter results
            cur_cwp = ~cwp; cur_s = ~s; cur_tbr = ~tbr; trap_type = ~tt;
            cur_pc = ~pc; cur_npc = ~npc;
        end
        check(busy && !done, "R2 first cycle", {busy, done}, 2'b10);
        @(posedge clk); #1;
        trap_req = 1'b0;
        check(busy && done, "R2 second cycle", {busy, done}, 2'b11);
        @(posedge clk); #1;
        check(!busy && !done, "R2 back to idle", {busy, done}, 2'b00);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(!busy && !done && !err_state && !rf_we, "R9 reset state",
              {busy, done, err_state, rf_we}, 0);
        rst_n = 1'b1;
        do_trap(3'd5, 1'b0, 32'h4000_0000, 8'h11, 32'h0000_1000, 32'h0000_1004, 1'b0);
        do_trap(3'd0, 1'b1, 32'hABCD_EFFF, 8'hFF, 32'h1234_5678, 32'h8765_4320, 1'b0); // R3 wrap
        do_trap(3'd7, 1'b1, 32'h0000_0FFF, 8'h00, 32'hFFFF_FFFC, 32'h0000_0000, 1'b0);
        do_trap(3'd1, 1'b0, 32'hF000_0123, 8'h5A, 32'h2222_0000, 32'h2222_0004, 1'b1); // R8
        do_trap(3'd4, 1'b1, 32'h8000_1000, 8'h80, 32'h0000_0040, 32'h0000_0044, 1'b1);
        check(rf_q.size() == 0 && cm_q.size() == 0, "R7 all items seen",
              rf_q.size() + cm_q.size(), 0);
        // R1: trap with traps disabled
        @(posedge clk); #1;
        cur_et = 1'b0; trap_req = 1'b1;
        @(posedge clk); #1;
        trap_req = 1'b0;
        check(err_state && !busy, "R1 error entered", {err_state, busy}, 2'b10);
        cur_et = 1'b1; trap_req = 1'b1;
        repeat (4) @(posedge clk);
        #1;
        trap_req = 1'b0;
        check(err_state && !busy && !done, "R1 error sticky", {err_state, busy, done}, 3'b100);
        rst_n = 1'b0;
        @(posedge clk); #1;
        check(!err_state && !busy, "R9 reset clears error", {err_state, busy}, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_P * 5000);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule